// File: doc/BRIEF.md
# Per-Bank Auto-Precharge Command Tracker

This block sits beside the command scheduler of an SDRAM controller for a four-bank device. Every clock it sees one command (activate, read, write, burst stop, precharge or no-op) with a bank field and an address word. It compares the command against the state it holds for each bank and returns a combinational accept/reject verdict in the same cycle. Accepted commands update the bank state at the next clock edge. Rejected commands change nothing.

Address bit 10 on a read or write asks for an implied precharge. The bank then finishes its burst and closes itself, with no precharge command from the scheduler. The precharge counts from the earliest legal point in the burst. The bank stays locked until the precharge recovery time has run out. Burst length and recovery time are configuration inputs that the scheduler holds steady while any bank is counting.

Each bank runs the same state machine. Its states and transitions are:
- IDLE goes to ACTIVE on an activate.
- ACTIVE, RD_BURST and WR_BURST go to RD_BURST or WR_BURST on a plain read or write.
- The same three states go to AP_BURST on a read or write with the implied-precharge bit set. When the precharge point falls in the very next cycle, they go straight to RECOVER.
- The same three states go to RECOVER on a precharge, or to IDLE when the recovery time is one cycle.
- RD_BURST goes to ACTIVE on a burst stop.
- RD_BURST and WR_BURST go to ACTIVE when their burst count runs out.
- AP_BURST goes to RECOVER at the precharge point.
- RECOVER goes to IDLE when the recovery count runs out.

Top module: `bank_ap_tracker`

## Requirements
- R1: After reset every bank is closed: bank_open and bank_busy are all 0, and bank_ready is all 1.
- R2: cmd_op encodes 0 no-op, 1 activate, 2 read, 3 write, 4 burst stop, 5 precharge. An activate to a closed, unlocked bank is accepted. The bank's bank_open bit then rises and open_rows slice [b*13 +: 13] holds cmd_addr. An activate to an open bank is rejected.
- R3: A read or write to a bank with no open row is rejected.
- R4: cfg_bl codes 0, 1, 2 and 3 give burst lengths 2, 4, 8 and 8. A plain read or write accepted in cycle t keeps bank_busy high in cycles t+1 through t+BL/2, and the bank is idle-but-open from t+BL/2+1.
- R5: cmd_addr[10] selects the implied precharge for that one read or write only. A plain read or write that follows never lowers bank_ready.
- R6: For a read with bit 10 set, accepted in cycle t, the precharge point is P = t+BL/2. Recovery time is R = cfg_trp, with 0 read as 1. Every command to that bank is rejected, and bank_ready is low, in cycles t+1 through P+R-1. An activate in cycle P+R is accepted.
- R7: For a write with bit 10 set, the precharge point is t+BL/2+1 (one cycle of write recovery). The lock is otherwise as in R6.
- R8: A precharge to an open bank in cycle t rejects activates to it until cycle t+R, where one is accepted. A precharge to a closed bank is accepted and has no effect.
- R9: A burst stop ignores cmd_bank and acts on the bank of the most recently accepted read or write. It is accepted only when that command was a read without bit 10 and the burst is still running; it then clears bank_busy in the next cycle. Otherwise it is rejected, including a second stop after an accepted one.
- R10: A bank that is locked or recovering does not affect commands to other banks.
- R11: Rejected commands, and opcodes 6 and 7, leave all outputs unchanged; a no-op is never rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command opcode (see R2) |
| cmd_bank | input | 2 | Target bank |
| cmd_addr | input | 13 | Row for activate, column plus bit-10 precharge flag for read/write |
| cfg_bl | input | 2 | Burst length code |
| cfg_trp | input | 4 | Precharge recovery time in cycles |
| cmd_reject | output | 1 | Current command is illegal and ignored |
| bank_open | output | 4 | Bank has an open row |
| bank_busy | output | 4 | Bank is bursting, locked or recovering |
| bank_ready | output | 4 | Bank is not locked by a pending or recovering precharge |
| open_rows | output | 52 | Row held per bank, 13 bits each |

## Verification
The hardest situation to reach is the exact edge of the lock window after an implied precharge. That edge moves with burst length, recovery time and command type, and a probe command must not disturb the bank it measures. The stimulus relies on the rule that rejected commands are ignored. After each read or write with bit 10 set, an activate goes to the same bank every cycle. Every one of them must be rejected until the single cycle where the first is accepted. This is swept over all burst-length codes, recovery times 0 to 4 and both command types. A directed sequence then drives the burst stop through its accepted case and each of its rejected cases.

// File: rtl/apt_pkg.sv
package apt_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_BT  = 3'd4,
        OP_PRE = 3'd5
    } apt_op_e;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_RD_BURST,
        BK_WR_BURST,
        BK_AP_BURST,
        BK_RECOVER
    } bank_st_e;

    // Half the burst length in clock cycles (two beats per clock)
    function automatic logic [3:0] half_burst(input logic [1:0] code);
        unique case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/apt_bank_fsm.sv
module apt_bank_fsm
    import apt_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CNT_W = 6,
    parameter int TWR   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_act,
    input  logic             go_rd,
    input  logic             go_wr,
    input  logic             go_pre,
    input  logic             go_bt,
    input  logic             ap,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CNT_W-1:0] half_len,
    input  logic [CNT_W-1:0] trp_eff,
    output bank_st_e         st,
    output logic [ROW_W-1:0] row_q
);

    bank_st_e         st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [ROW_W-1:0] row_n;
    logic [CNT_W-1:0] pre_pt;

    // Distance from the command to the implied precharge point
    assign pre_pt = go_wr ? half_len + CNT_W'(TWR) : half_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= BK_IDLE;
            cnt   <= '0;
            row_q <= '0;
        end else begin
            st    <= st_n;
            cnt   <= cnt_n;
            row_q <= row_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        row_n = row_q;
        unique case (st)
            BK_IDLE: begin
                if (go_act) begin
                    st_n  = BK_ACTIVE;
                    row_n = row_in;
                end
            end
            BK_ACTIVE, BK_RD_BURST, BK_WR_BURST: begin
                if (go_rd || go_wr) begin
                    if (ap) begin
                        if (pre_pt == CNT_W'(1)) begin
                            st_n  = BK_RECOVER;
                            cnt_n = trp_eff;
                        end else begin
                            st_n  = BK_AP_BURST;
                            cnt_n = pre_pt - CNT_W'(1);
                        end
                    end else begin
                        st_n  = go_rd ? BK_RD_BURST : BK_WR_BURST;
                        cnt_n = half_len;
                    end
                end else if (go_pre) begin
                    if (trp_eff == CNT_W'(1)) begin
                        st_n = BK_IDLE;
                    end else begin
                        st_n  = BK_RECOVER;
                        cnt_n = trp_eff - CNT_W'(1);
                    end
                end else if (go_bt) begin
                    st_n = BK_ACTIVE;
                end else if (st != BK_ACTIVE) begin
                    if (cnt == CNT_W'(1)) st_n = BK_ACTIVE;
                    else                  cnt_n = cnt - CNT_W'(1);
                end
            end
            BK_AP_BURST: begin
                if (cnt == CNT_W'(1)) begin
                    st_n  = BK_RECOVER;
                    cnt_n = trp_eff;
                end else begin
                    cnt_n = cnt - CNT_W'(1);
                end
            end
            BK_RECOVER: begin
                if (cnt == CNT_W'(1)) st_n = BK_IDLE;
                else                  cnt_n = cnt - CNT_W'(1);
            end
            default: st_n = BK_IDLE;
        endcase
    end

    // R6
    bank_locked_no_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_AP_BURST || st == BK_RECOVER) |-> !(go_act || go_rd || go_wr || go_pre || go_bt));

    // R8
    recover_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_RECOVER) |=> (st == BK_RECOVER || st == BK_IDLE));

    // R5
    plain_read_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_rd && !ap) |=> (st == BK_RD_BURST));

    // R9
    stop_only_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_bt |-> (st == BK_RD_BURST));

    // R4
    count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BK_RD_BURST || st == BK_WR_BURST || st == BK_AP_BURST || st == BK_RECOVER)
        |-> (cnt != '0));

endmodule

// File: rtl/apt_cmd_check.sv
module apt_cmd_check
    import apt_pkg::*;
#(
    parameter int NB     = 4,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [BANK_W-1:0] bank,
    input  logic              ap,
    input  bank_st_e          st [NB],
    output logic              reject,
    output logic [NB-1:0]     go_act,
    output logic [NB-1:0]     go_rd,
    output logic [NB-1:0]     go_wr,
    output logic [NB-1:0]     go_pre,
    output logic [NB-1:0]     go_bt
);

    logic [BANK_W-1:0] last_bank;
    logic              last_plain_rd;
    logic [BANK_W-1:0] target;
    bank_st_e          sel_st;
    logic              ok;
    logic              open_st;

    assign target  = (op == OP_BT) ? last_bank : bank;
    assign sel_st  = st[target];
    assign open_st = (sel_st == BK_ACTIVE) || (sel_st == BK_RD_BURST) || (sel_st == BK_WR_BURST);

    always_comb begin
        unique case (op)
            OP_NOP:        ok = 1'b1;
            OP_ACT:        ok = (sel_st == BK_IDLE);
            OP_RD, OP_WR:  ok = open_st;
            OP_PRE:        ok = open_st || (sel_st == BK_IDLE);
            OP_BT:         ok = last_plain_rd && (sel_st == BK_RD_BURST);
            default:       ok = 1'b0;
        endcase
    end

    assign reject = !ok;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            go_act[i] = ok && (op == OP_ACT) && (target == BANK_W'(i));
            go_rd[i]  = ok && (op == OP_RD)  && (target == BANK_W'(i));
            go_wr[i]  = ok && (op == OP_WR)  && (target == BANK_W'(i));
            go_pre[i] = ok && (op == OP_PRE) && (target == BANK_W'(i));
            go_bt[i]  = ok && (op == OP_BT)  && (target == BANK_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_bank     <= '0;
            last_plain_rd <= 1'b0;
        end else if (ok && (op == OP_RD || op == OP_WR)) begin
            last_bank     <= bank;
            last_plain_rd <= (op == OP_RD) && !ap;
        end else if (ok && op == OP_BT) begin
            last_plain_rd <= 1'b0;
        end
    end

    // R9
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BT && !reject) |=> !(op == OP_BT && !reject));

    // R11
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({go_act, go_rd, go_wr, go_pre, go_bt}) <= 1);

endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
    import apt_pkg::*;
#(
    parameter int NB    = 4,
    parameter int ROW_W = 13,
    parameter int TRP_W = 4,
    parameter int TWR   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cmd_op,
    input  logic [1:0]          cmd_bank,
    input  logic [ROW_W-1:0]    cmd_addr,
    input  logic [1:0]          cfg_bl,
    input  logic [TRP_W-1:0]    cfg_trp,
    output logic                cmd_reject,
    output logic [NB-1:0]       bank_open,
    output logic [NB-1:0]       bank_busy,
    output logic [NB-1:0]       bank_ready,
    output logic [NB*ROW_W-1:0] open_rows
);

    localparam int BANK_W = $clog2(NB);
    localparam int CNT_W  = TRP_W + 2;
    localparam int AP_BIT = 10;

    bank_st_e         bank_st [NB];
    logic [NB-1:0]    go_act, go_rd, go_wr, go_pre, go_bt;
    logic [CNT_W-1:0] half_len, trp_eff;

    assign half_len = CNT_W'(half_burst(cfg_bl));
    assign trp_eff  = (cfg_trp == '0) ? CNT_W'(1) : CNT_W'(cfg_trp);

    apt_cmd_check #(.NB(NB), .BANK_W(BANK_W)) i_check (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (cmd_op),
        .bank   (cmd_bank[BANK_W-1:0]),
        .ap     (cmd_addr[AP_BIT]),
        .st     (bank_st),
        .reject (cmd_reject),
        .go_act (go_act),
        .go_rd  (go_rd),
        .go_wr  (go_wr),
        .go_pre (go_pre),
        .go_bt  (go_bt)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        apt_bank_fsm #(.ROW_W(ROW_W), .CNT_W(CNT_W), .TWR(TWR)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .go_act   (go_act[b]),
            .go_rd    (go_rd[b]),
            .go_wr    (go_wr[b]),
            .go_pre   (go_pre[b]),
            .go_bt    (go_bt[b]),
            .ap       (cmd_addr[AP_BIT]),
            .row_in   (cmd_addr),
            .half_len (half_len),
            .trp_eff  (trp_eff),
            .st       (bank_st[b]),
            .row_q    (open_rows[b*ROW_W +: ROW_W])
        );
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            bank_open[b]  = (bank_st[b] == BK_ACTIVE)   || (bank_st[b] == BK_RD_BURST) ||
                            (bank_st[b] == BK_WR_BURST) || (bank_st[b] == BK_AP_BURST);
            bank_busy[b]  = (bank_st[b] == BK_RD_BURST) || (bank_st[b] == BK_WR_BURST) ||
                            (bank_st[b] == BK_AP_BURST) || (bank_st[b] == BK_RECOVER);
            bank_ready[b] = !((bank_st[b] == BK_AP_BURST) || (bank_st[b] == BK_RECOVER));
        end
    end

    // R10
    locked_act_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_ACT && !bank_ready[cmd_bank[BANK_W-1:0]]) |-> cmd_reject);

    // R11
    nop_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == OP_NOP) |-> !cmd_reject);

endmodule

// File: tb/test_bank_ap_tracker.sv
module test_bank_ap_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic [12:0] cmd_addr = 13'd0;
    logic [1:0]  cfg_bl = 2'd0;
    logic [3:0]  cfg_trp = 4'd1;
    logic        cmd_reject;
    logic [3:0]  bank_open, bank_busy, bank_ready;
    logic [51:0] open_rows;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, BT = 3'd4, PRE = 3'd5;

    always #2 clk = ~clk;

    bank_ap_tracker i_bank_ap_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cfg_bl(cfg_bl), .cfg_trp(cfg_trp), .cmd_reject(cmd_reject), .bank_open(bank_open),
        .bank_busy(bank_busy), .bank_ready(bank_ready), .open_rows(open_rows)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [2:0] op, input int b, input logic [12:0] addr);
        @(negedge clk);
        cmd_op   = op;
        cmd_bank = 2'(b);
        cmd_addr = addr;
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(NOP, 0, 13'd0);
    endtask

    function automatic int half_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    initial begin
        #800000;
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bsel;
        bsel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(bank_open == 4'h0, "R1 open", int'(bank_open), 0);
        chk(bank_busy == 4'h0, "R1 busy", int'(bank_busy), 0);
        chk(bank_ready == 4'hF, "R1 ready", int'(bank_ready), 15);

        // Sweep over burst length, recovery and command type
        for (int bl = 0; bl < 4; bl++) begin
            for (int trp = 0; trp < 5; trp++) begin
                for (int w = 0; w < 2; w++) begin
                    int hb, pp, rr, lk, b;
                    logic [2:0] op;
                    logic [12:0] row;
                    hb = half_of(bl);
                    rr = (trp == 0) ? 1 : trp;
                    op = w ? WR : RD;
                    pp = w ? hb + 1 : hb;
                    lk = pp + rr;
                    b  = bsel % 4;
                    bsel++;
                    row = 13'(17 * bsel + 3) & 13'h1BFF;
                    cfg_bl  = 2'(bl);
                    cfg_trp = 4'(trp);
                    cyc(ACT, b, row);
                    chk(!cmd_reject, "R2 act accept", int'(cmd_reject), 0);
                    cyc(NOP, 0, 0);
                    chk(bank_open[b], "R2 open", int'(bank_open[b]), 1);
                    chk(open_rows[b*13 +: 13] == row, "R2 row", int'(open_rows[b*13 +: 13]), int'(row));
                    // plain burst
                    cyc(op, b, 13'h0005);
                    chk(!cmd_reject, "R3 rw accept", int'(cmd_reject), 0);
                    for (int j = 1; j <= hb + 1; j++) begin
                        cyc(NOP, 0, 0);
                        chk(bank_busy[b] == (j <= hb), "R4 busy", int'(bank_busy[b]), int'(j <= hb));
                        chk(bank_ready[b], "R5 ready", int'(bank_ready[b]), 1);
                    end
                    // implied precharge
                    cyc(op, b, 13'h0405);
                    chk(!cmd_reject, "R6 ap accept", int'(cmd_reject), 0);
                    for (int j = 1; j <= lk; j++) begin
                        cyc(ACT, b, row);
                        chk(cmd_reject == (j < lk), w ? "R7 lock" : "R6 lock", int'(cmd_reject), int'(j < lk));
                        chk(bank_ready[b] == (j >= lk), w ? "R7 ready" : "R6 ready", int'(bank_ready[b]), int'(j >= lk));
                    end
                    // explicit precharge
                    cyc(PRE, b, 0);
                    chk(!cmd_reject, "R8 pre accept", int'(cmd_reject), 0);
                    for (int j = 1; j <= rr; j++) begin
                        cyc(ACT, b, row);
                        chk(cmd_reject == (j < rr), "R8 recover", int'(cmd_reject), int'(j < rr));
                    end
                    cyc(PRE, b, 0);
                    idle(rr + 1);
                    chk(bank_open[b] == 1'b0, "R8 closed", int'(bank_open[b]), 0);
                end
            end
        end

        cfg_bl = 2'd2;
        cfg_trp = 4'd3;
        // R3 read to closed bank
        cyc(RD, 2, 0);
        chk(cmd_reject, "R3 closed rd", int'(cmd_reject), 1);
        cyc(NOP, 0, 0);
        chk(bank_open[2] == 1'b0, "R11 no effect", int'(bank_open[2]), 0);
        // R8 precharge to a closed bank
        cyc(PRE, 3, 0);
        chk(!cmd_reject, "R8 pre idle", int'(cmd_reject), 0);
        cyc(NOP, 0, 0);
        chk(bank_busy[3] == 1'b0 && bank_ready[3], "R8 idle no effect", int'(bank_busy[3]), 0);
        // R2 second activate rejected, row kept
        cyc(ACT, 1, 13'h0123);
        cyc(ACT, 1, 13'h0456);
        chk(cmd_reject, "R2 double act", int'(cmd_reject), 1);
        cyc(NOP, 0, 0);
        chk(open_rows[13 +: 13] == 13'h0123, "R11 row kept", int'(open_rows[13 +: 13]), 'h123);
        // R11 reserved opcodes and no-op
        cyc(3'd6, 1, 0);
        chk(cmd_reject, "R11 op6", int'(cmd_reject), 1);
        cyc(3'd7, 1, 0);
        chk(cmd_reject, "R11 op7", int'(cmd_reject), 1);
        cyc(NOP, 1, 0);
        chk(!cmd_reject, "R11 nop", int'(cmd_reject), 0);
        chk(bank_busy == 4'h0, "R11 reserved no effect", int'(bank_busy), 0);

        // R9 burst stop cases (BL 8, four-cycle burst)
        cyc(RD, 1, 0);
        cyc(BT, 3, 0);
        chk(!cmd_reject, "R9 stop accept", int'(cmd_reject), 0);
        cyc(BT, 1, 0);
        chk(cmd_reject, "R9 second stop", int'(cmd_reject), 1);
        chk(bank_busy[1] == 1'b0, "R9 truncated", int'(bank_busy[1]), 0);
        cyc(WR, 1, 0);
        cyc(BT, 1, 0);
        chk(cmd_reject, "R9 stop write", int'(cmd_reject), 1);
        idle(5);
        cyc(RD, 1, 0);
        idle(5);
        cyc(BT, 1, 0);
        chk(cmd_reject, "R9 stop after end", int'(cmd_reject), 1);
        cyc(RD, 1, 13'h0400);
        cyc(BT, 1, 0);
        chk(cmd_reject, "R9 stop ap read", int'(cmd_reject), 1);
        idle(10);

        // R10 other banks while bank 0 recovers
        cfg_trp = 4'd4;
        cyc(ACT, 0, 13'h0011);
        cyc(ACT, 2, 13'h0022);
        cyc(RD, 0, 13'h0400);
        cyc(ACT, 3, 13'h0033);
        chk(!cmd_reject, "R10 act other", int'(cmd_reject), 0);
        cyc(RD, 2, 0);
        chk(!cmd_reject, "R10 rd other", int'(cmd_reject), 0);
        chk(bank_ready[2] && !bank_ready[0], "R10 ready split", int'(bank_ready), 'b1110);
        idle(12);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule